// File: doc/BRIEF.md
# PCM Serial Byte Port with Frame Sync Width Detection

This block moves one 8-bit PCM word per frame in each direction over a serial link. On the transmit side it takes a parallel byte. When a frame begins it drives the byte most significant bit first onto a serial output that has its own enable, and it releases the line when the word is done. On the receive side it samples the serial input on falling bit clock edges and assembles eight bits. It then presents the byte with a one-cycle valid strobe.

The block measures the width of each transmit frame sync pulse. It counts the falling bit clock edges during which the sync is high. One or two such edges mean short framing, and three or more mean long framing. The result sets the framing mode for both directions from the next frame on. Short framing arms a frame on the falling edge that sees the sync high. Long framing starts from the rising edge of the sync itself, and it can keep the output enabled until the sync drops. All pins are sampled with a fast system clock, so each bit clock edge is seen as a one-cycle event. A select input lets the receive side run from the transmit bit clock.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset the serial output enable is low, the receive valid strobe is low, and the framing mode is short.
- R2: The framing mode changes only when the transmit sync falls. It becomes long if at least three falling transmit bit clock edges saw the sync high during that pulse, and short otherwise (a two-period sync is short). The mode in force when a frame starts governs the whole frame, in both directions.
- R3: In short mode, a falling transmit bit clock edge with the transmit sync high arms a frame. The next rising edge sets the output enable and drives bit 7 of the captured byte.
- R4: In short mode, the next seven rising edges drive bits 6 down to 0. The output data is stable between rising edges. The falling edge after the eighth rising edge clears the output enable.
- R5: In long mode, the output enable is set at the rising edge of the transmit sync if the bit clock is high at that moment. Otherwise it is set at the next rising bit clock edge. Bit 7 is driven first.
- R6: In long mode, the seven rising bit clock edges after the enable point drive bits 6 down to 0. The enable clears at whichever comes later: the falling edge after the eighth bit starts, or the transmit sync going low. While it waits for the sync, the last bit is held.
- R7: In short mode, a falling receive bit clock edge with the receive sync high arms reception, and that edge latches nothing. The next eight falling edges latch bits 7 down to 0 from the serial input. One cycle after the eighth edge is detected, the byte appears with a valid strobe that is high for exactly one cycle. The byte is held until the next strobe.
- R8: In long mode, a rising edge of the receive sync causes the next eight falling receive bit clock edges, strictly after it, to latch bits 7 down to 0. The byte is presented as in R7.
- R9: With the clock select high, the receive side uses the transmit bit clock, and the receive bit clock pin has no effect. With it low, the receive side uses its own bit clock, and a quiet transmit side keeps the output enable low.
- R10: The transmit byte is captured at the enable point. Changes on the parallel input after that point do not alter the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_share | input | 1 | High: receive side uses the transmit bit clock |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync |
| tx_word | input | 8 | Parallel byte to send |
| tx_sdata | output | 1 | Serial data out, meaningful while enabled |
| tx_sdata_en | output | 1 | Output enable of the serial data line |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_sdata | input | 1 | Serial data in |
| rx_word | output | 8 | Last received byte |
| rx_word_vld | output | 1 | One-cycle strobe for a new received byte |

## Verification
A wrong framing mode shows on the next frame as an enable edge that is one bit period off. In long frames it can also show as an enable that drops before the sync falls. A slipped transmit bit counter shows within one bit period as a wrong data bit, or as an enable that stays on too long. A receive side that arms on the wrong edge shows when its strobe arrives one bit period early or late, carrying a byte shifted by one position. The bench compares every cycle of every frame against expected values that it computes from the sync and clock timing, so such faults show up within that frame.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARM   = 2'd1,
    TX_SHIFT = 2'd2,
    TX_HOLD  = 2'd3
  } tx_state_e;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;
endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic sig_lvl,
  output logic sig_rise,
  output logic sig_fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_in;
  end

  assign sig_lvl  = sig_in;
  assign sig_rise = sig_in & ~prev_q;
  assign sig_fall = ~sig_in & prev_q;
endmodule

// File: rtl/pcm_width_det.sv
module pcm_width_det #(
  parameter int LONG_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_fall,
  input  logic fs_lvl,
  input  logic fs_fall,
  output logic long_mode
);
  localparam int CW = $clog2(LONG_MIN + 1);
  localparam logic [CW-1:0] SAT = CW'(LONG_MIN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          long_q, long_d;

  always_comb begin
    cnt_d  = cnt_q;
    long_d = long_q;
    if (fs_fall) begin
      long_d = (cnt_q >= SAT);
      cnt_d  = '0;
    end else if (bclk_fall && fs_lvl && (cnt_q != SAT)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      long_q <= long_d;
    end
  end

  assign long_mode = long_q;

  AST_MODE_ON_FS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(long_q) |-> $past(fs_fall)); // R2
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
  import pcm_port_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_lvl,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              fs_lvl,
  input  logic              fs_rise,
  input  logic              long_mode,
  input  logic [WORD_W-1:0] word_in,
  output logic              sdata,
  output logic              sdata_en
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  tx_state_e         state_q, state_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              flong_q, flong_d;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    flong_d = flong_q;
    unique case (state_q)
      TX_IDLE: begin
        if (long_mode) begin
          if (fs_rise) begin
            flong_d = 1'b1;
            if (bclk_lvl) begin
              state_d = TX_SHIFT;
              shreg_d = word_in;
              cnt_d   = '0;
            end else begin
              state_d = TX_ARM;
            end
          end
        end else if (bclk_fall && fs_lvl) begin
          flong_d = 1'b0;
          state_d = TX_ARM;
        end
      end
      TX_ARM: begin
        if (bclk_rise) begin
          state_d = TX_SHIFT;
          shreg_d = word_in;
          cnt_d   = '0;
        end
      end
      TX_SHIFT: begin
        if (bclk_rise && (cnt_q != LAST)) begin
          shreg_d = {shreg_q[WORD_W-2:0], 1'b0};
          cnt_d   = cnt_q + 1'b1;
        end else if (bclk_fall && (cnt_q == LAST)) begin
          state_d = (flong_q && fs_lvl) ? TX_HOLD : TX_IDLE;
        end
      end
      TX_HOLD: begin
        if (!fs_lvl) state_d = TX_IDLE;
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      flong_q <= 1'b0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      flong_q <= flong_d;
    end
  end

  assign sdata_en = (state_q == TX_SHIFT) || (state_q == TX_HOLD);
  assign sdata    = sdata_en & shreg_q[WORD_W-1];

  AST_TX_EN_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_en) |-> $past(bclk_rise || fs_rise)); // R3
  AST_TX_DIS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdata_en) |-> $past(bclk_fall || !fs_lvl)); // R4
  AST_TX_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata_en && $past(sdata_en) && !$past(bclk_rise)) |-> $stable(sdata)); // R4
  AST_TX_HOLD_NEEDS_FS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_HOLD) |-> $past(fs_lvl)); // R6
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx
  import pcm_port_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_fall,
  input  logic              fs_lvl,
  input  logic              fs_rise,
  input  logic              long_mode,
  input  logic              sdata,
  output logic [WORD_W-1:0] word_out,
  output logic              word_vld
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  rx_state_e         state_q, state_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              vld_q, vld_d;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    word_d  = word_q;
    cnt_d   = cnt_q;
    vld_d   = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (long_mode ? fs_rise : (bclk_fall && fs_lvl)) begin
          state_d = RX_RUN;
          cnt_d   = '0;
        end
      end
      RX_RUN: begin
        if (bclk_fall) begin
          shreg_d = {shreg_q[WORD_W-2:0], sdata};
          cnt_d   = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            word_d  = {shreg_q[WORD_W-2:0], sdata};
            vld_d   = 1'b1;
            state_d = RX_IDLE;
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      shreg_q <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      word_q  <= word_d;
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
    end
  end

  assign word_out = word_q;
  assign word_vld = vld_q;

  AST_RX_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld); // R7
  AST_RX_VLD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(bclk_fall)); // R8
  AST_RX_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |-> $stable(word_out)); // R7
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int WORD_W   = 8,
  parameter int LONG_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_share,
  input  logic              tx_bclk,
  input  logic              tx_fsync,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_sdata,
  output logic              tx_sdata_en,
  input  logic              rx_bclk,
  input  logic              rx_fsync,
  input  logic              rx_sdata,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_word_vld
);
  localparam int N_PIN = 4;
  localparam int P_TXB = 0;
  localparam int P_TXF = 1;
  localparam int P_RXB = 2;
  localparam int P_RXF = 3;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [N_PIN-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  logic             rx_bclk_sel;
  logic             long_mode;

  assign rx_bclk_sel = clk_share ? tx_bclk : rx_bclk;
  assign pin_raw[P_TXB] = tx_bclk;
  assign pin_raw[P_TXF] = tx_fsync;
  assign pin_raw[P_RXB] = rx_bclk_sel;
  assign pin_raw[P_RXF] = rx_fsync;

  for (genvar g = 0; g < N_PIN; g++) begin : g_edge
    pcm_edge_det i_edge (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .sig_in   (pin_raw[g]),
      .sig_lvl  (pin_lvl[g]),
      .sig_rise (pin_rise[g]),
      .sig_fall (pin_fall[g])
    );
  end

  pcm_width_det #(.LONG_MIN(LONG_MIN)) i_width (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bclk_fall (pin_fall[P_TXB]),
    .fs_lvl    (pin_lvl[P_TXF]),
    .fs_fall   (pin_fall[P_TXF]),
    .long_mode (long_mode)
  );

  pcm_tx #(.WORD_W(WORD_W)) i_tx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bclk_lvl  (pin_lvl[P_TXB]),
    .bclk_rise (pin_rise[P_TXB]),
    .bclk_fall (pin_fall[P_TXB]),
    .fs_lvl    (pin_lvl[P_TXF]),
    .fs_rise   (pin_rise[P_TXF]),
    .long_mode (long_mode),
    .word_in   (tx_word),
    .sdata     (tx_sdata),
    .sdata_en  (tx_sdata_en)
  );

  pcm_rx #(.WORD_W(WORD_W)) i_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bclk_fall (pin_fall[P_RXB]),
    .fs_lvl    (pin_lvl[P_RXF]),
    .fs_rise   (pin_rise[P_RXF]),
    .long_mode (long_mode),
    .sdata     (rx_sdata),
    .word_out  (rx_word),
    .word_vld  (rx_word_vld)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |=> (!tx_sdata_en && !rx_word_vld)); // R1
endmodule

// File: tb/test_pcm_serial_port.sv
module test_pcm_serial_port;
  localparam int H  = 4;
  localparam int NH = 30;
  localparam int NT = NH * H;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_share = 1'b0;
  logic       tx_bclk = 1'b0, tx_fsync = 1'b0;
  logic [7:0] tx_word = 8'h00;
  logic       tx_sdata, tx_sdata_en;
  logic       rx_bclk = 1'b0, rx_fsync = 1'b0, rx_sdata = 1'b0;
  logic [7:0] rx_word;
  logic       rx_word_vld;

  int n_chk = 0;
  int n_fail = 0;
  bit mode_long_exp = 1'b0;

  always #5 clk = ~clk;

  pcm_serial_port i_pcm_serial_port (
    .clk(clk), .rst_n(rst_n), .clk_share(clk_share),
    .tx_bclk(tx_bclk), .tx_fsync(tx_fsync), .tx_word(tx_word),
    .tx_sdata(tx_sdata), .tx_sdata_en(tx_sdata_en),
    .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .rx_sdata(rx_sdata),
    .rx_word(rx_word), .rx_word_vld(rx_word_vld)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit fs_at(input int t, input int ta, input int tb);
    return (t >= ta) && (t < tb);
  endfunction

  // Drives one frame and checks every cycle against expected timing.
  task automatic run_frame(input bit sm, input int a, input int oa, input int wper,
                           input logic [7:0] txb, input string pre);
    int ta, tb, h0, e, ten, tdis, hl, tval, nf, n;
    bit lf, bl, oe_e;
    logic rxbits [NH];
    logic [7:0] rxexp;
    string t_oe, t_dat, t_rx;
    ta = a * H + oa;
    tb = (a + 2 * wper) * H + oa;
    lf = mode_long_exp;
    for (int h = 0; h < NH; h++) rxbits[h] = 1'($urandom);
    h0 = -1;
    for (int h = 1; h < NH; h += 2)
      if (h0 < 0 && fs_at(h * H, ta, tb)) h0 = h;
    if (lf) begin
      e = (a % 2 == 0) ? a : a + 1;
      ten = (a % 2 == 0) ? ta : e * H;
      tdis = ((e + 15) * H > tb) ? (e + 15) * H : tb;
      hl = -1;
      for (int h = 1; h < NH; h += 2)
        if (hl < 0 && h * H > ta) hl = h;
    end else begin
      e = h0 + 1;
      ten = e * H;
      tdis = (e + 15) * H;
      hl = h0 + 2;
    end
    tval = (hl + 14) * H;
    for (int k = 0; k < 8; k++) rxexp[7-k] = rxbits[hl + 2 * k];
    t_oe  = {pre, lf ? "R5 R2" : "R3 R2"};
    t_dat = {pre, lf ? "R6 R10" : "R4 R10"};
    t_rx  = {pre, lf ? "R8" : "R7", sm ? " R9" : ""};

    for (int t = 0; t <= NT; t++) begin
      @(negedge clk);
      if (t > 0) begin
        int u;
        u = t - 1;
        if (sm) begin
          oe_e = (u >= ten) && (u < tdis);
          chk(tx_sdata_en == oe_e, t_oe, int'(tx_sdata_en), int'(oe_e));
          if (oe_e && tx_sdata_en) begin
            n = (u / H - e) / 2;
            if (n > 7) n = 7;
            chk(tx_sdata == txb[7-n], t_dat, int'(tx_sdata), int'(txb[7-n]));
          end
        end else begin
          chk(tx_sdata_en == 1'b0, {pre, "R9"}, int'(tx_sdata_en), 0);
        end
        chk(rx_word_vld == (u == tval), t_rx, int'(rx_word_vld), int'(u == tval));
        if (u == tval) chk(rx_word == rxexp, t_rx, int'(rx_word), int'(rxexp));
      end
      if (t < NT) begin
        bl = ((t / H) % 2 == 0);
        clk_share <= sm;
        rx_fsync  <= fs_at(t, ta, tb);
        rx_sdata  <= rxbits[(t / H) | 1];
        tx_word   <= (sm && t > ten) ? ~txb : txb;
        if (sm) begin
          tx_bclk  <= bl;
          tx_fsync <= fs_at(t, ta, tb);
          rx_bclk  <= 1'($urandom);
        end else begin
          tx_bclk  <= 1'b0;
          tx_fsync <= 1'b0;
          rx_bclk  <= bl;
        end
      end
    end
    if (sm) begin
      nf = 0;
      for (int h = 1; h < NH; h += 2) if (fs_at(h * H, ta, tb)) nf++;
      mode_long_exp = (nf >= 3);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    chk(tx_sdata_en == 1'b0, "R1", int'(tx_sdata_en), 0);
    chk(rx_word_vld == 1'b0, "R1", int'(rx_word_vld), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(tx_sdata_en == 1'b0, "R1", int'(tx_sdata_en), 0);
    chk(rx_word_vld == 1'b0, "R1", int'(rx_word_vld), 0);
    // Directed corner cases
    run_frame(1'b1, 2, 0, 4, 8'hA5, "R1 ");  // first frame after reset is short
    run_frame(1'b1, 3, 1, 2, 8'h3C, "");     // two-period sync stays short
    run_frame(1'b1, 2, 2, 3, 8'hF0, "");     // three periods: next is long
    run_frame(1'b1, 3, 0, 3, 8'h81, "");     // long, sync rises while clock low
    run_frame(1'b1, 2, 2, 8, 8'h5A, "");     // long, sync rises mid high, held past 8th bit
    run_frame(1'b0, 2, 0, 1, 8'hC3, "");     // async receive, long
    run_frame(1'b1, 4, 0, 1, 8'h0F, "");     // long frame with short sync: next short
    run_frame(1'b0, 3, 2, 1, 8'h96, "");     // async receive, short
    run_frame(1'b1, 2, 0, 1, 8'hFF, "");
    // Constrained random frames
    for (int i = 0; i < 40; i++) begin
      bit sm;
      int w;
      sm = ($urandom % 4) != 0;
      w  = 1 + int'($urandom % 8);
      run_frame(sm, 2 + int'($urandom % 4), int'($urandom % H), w, 8'($urandom), "");
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1-timeout actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule